// File: doc/BRIEF.md
# Masked Interrupt Status Controller

This block gathers hardware events into a sixteen-bit sticky status word and drives one level-sensitive interrupt line. The line is high whenever some status bit is set while the matching bit of a sixteen-bit mask word is clear. Software reaches both words through a small byte-wide register port. Each word is split into a low byte and a high byte. Events are cleared by writing ones to a separate low or high acknowledge byte.

Four event sources feed the status word. Three are one-cycle pulses from a real-time-clock block: a periodic tick, an alarm match and a failed time update. The fourth is the level of a power button, and the block detects its rising edge itself. The port writes on a synchronous strobe and reads through combinational logic. It has no handshake.

Top module: `irq_status_ctrl`

## Requirements
- R1: After reset the mask word is 0x0FFF, the status word is 0x0000 and `irq` is low.
- R2: `irq` is high exactly when (status AND NOT mask) is non-zero. It follows a status or mask change in the same cycle that the register changes.
- R3: A write to address 0x0 (mask low) loads mask bits 7:0 from `wr_data` and leaves bits 15:8 unchanged. A read of address 0x0 returns mask bits 7:0.
- R4: A write to address 0x1 (mask high) loads mask bits 15:8 and leaves bits 7:0 unchanged. A read of address 0x1 returns mask bits 15:8.
- R5: A write to address 0x4 (ack low) clears every status bit in 7:0 whose written bit is one. All other status bits are kept.
- R6: A write to address 0x5 (ack high) clears every status bit in 15:8 whose written bit is one. All other status bits are kept.
- R7: Reads of addresses 0x4 and 0x5, and of any address other than 0x0 to 0x5, return 0x00.
- R8: A one-cycle pulse sets a status bit at the next clock edge, and the bit stays set until it is acknowledged. The pulse sources map as follows: `rtc_tick` sets bit 8, `rtc_alarm` sets bit 9 and `rtc_upd_err` sets bit 10. Status is read at address 0x2 (bits 7:0) and address 0x3 (bits 15:8). No other source sets any status bit.
- R9: Status bit 11 is set only at a low-to-high transition of `pwr_btn`. Holding `pwr_btn` high does not set it again after an acknowledge.
- R10: If an event and an acknowledge hit the same status bit in the same cycle, the bit ends up set.
- R11: Writes to the status addresses 0x2 and 0x3 leave the status word unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe, sampled at the rising clock edge |
| addr | input | 4 | Register address for reads and writes |
| wr_data | input | 8 | Write byte |
| rd_data | output | 8 | Combinational read byte for `addr` |
| pwr_btn | input | 1 | Power-button level (already synchronous) |
| rtc_tick | input | 1 | Periodic tick pulse |
| rtc_alarm | input | 1 | Alarm pulse |
| rtc_upd_err | input | 1 | Time-update error pulse |
| irq | output | 1 | Level interrupt request |

## Verification
A register write takes effect at the clock edge that samples the strobe. The result can be read back from the next cycle, and `irq` changes in that same cycle. An event pulse, or a button level that was low one cycle earlier, shows in status one cycle after it is sampled. Read data is combinational, so a read is due in the cycle that `addr` is presented.

The bench follows this timing directly. Its driver changes inputs one time unit after a rising edge, and it queues the expected byte or `irq` level. The monitor then compares at the following falling edge, which falls after every register on the path has been updated.

// File: rtl/irq_stat_pkg.sv
package irq_stat_pkg;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 4;
  localparam int WORD_W = 2 * DATA_W;
  localparam int NBYTE  = WORD_W / DATA_W;

  localparam logic [ADDR_W-1:0] A_MASK_LO = 4'h0;
  localparam logic [ADDR_W-1:0] A_MASK_HI = 4'h1;
  localparam logic [ADDR_W-1:0] A_STAT_LO = 4'h2;
  localparam logic [ADDR_W-1:0] A_STAT_HI = 4'h3;
  localparam logic [ADDR_W-1:0] A_ACK_LO  = 4'h4;
  localparam logic [ADDR_W-1:0] A_ACK_HI  = 4'h5;

  localparam int TICK_BIT   = 8;
  localparam int ALARM_BIT  = 9;
  localparam int UPDERR_BIT = 10;
  localparam int BTN_BIT    = 11;

  localparam logic [WORD_W-1:0] MASK_RST = 16'h0FFF;
  localparam logic [WORD_W-1:0] EVT_BITS =
    (WORD_W'(1) << TICK_BIT) | (WORD_W'(1) << ALARM_BIT) |
    (WORD_W'(1) << UPDERR_BIT) | (WORD_W'(1) << BTN_BIT);
endpackage

// File: rtl/irq_rise_detect.sv
module irq_rise_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl,
  output logic rise
);
  logic prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= lvl;
  end

  assign rise = lvl & ~prev_q;

  // R9
  no_double_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise);
endmodule

// File: rtl/irq_byte_mask_reg.sv
module irq_byte_mask_reg #(
  parameter int WORD_W = 16,
  parameter int DATA_W = 8,
  parameter logic [WORD_W-1:0] RST_VAL = '1,
  localparam int NBYTE = WORD_W / DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NBYTE-1:0]  wr_byte,
  input  logic [DATA_W-1:0] wr_data,
  output logic [WORD_W-1:0] mask
);
  for (genvar b = 0; b < NBYTE; b++) begin : g_byte
    always_ff @(posedge clk) begin
      if (!rst_n)          mask[b*DATA_W +: DATA_W] <= RST_VAL[b*DATA_W +: DATA_W];
      else if (wr_byte[b]) mask[b*DATA_W +: DATA_W] <= wr_data;
    end

    // R3 R4
    byte_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_byte[b] |=> mask[b*DATA_W +: DATA_W] == $past(wr_data));
    // R3 R4
    byte_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_byte[b] |=> $stable(mask[b*DATA_W +: DATA_W]));
  end
endmodule

// File: rtl/irq_sticky_status.sv
module irq_sticky_status #(
  parameter int WORD_W = 16,
  parameter int DATA_W = 8,
  localparam int NBYTE = WORD_W / DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] set,
  input  logic [NBYTE-1:0]  ack_byte,
  input  logic [DATA_W-1:0] ack_data,
  output logic [WORD_W-1:0] status
);
  logic [WORD_W-1:0] clr;

  for (genvar b = 0; b < NBYTE; b++) begin : g_clr
    assign clr[b*DATA_W +: DATA_W] = ack_byte[b] ? ack_data : '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) status <= '0;
    else        status <= (status & ~clr) | set;
  end

  // R10
  set_sticks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|set) |=> ((status & $past(set)) == $past(set)));
  // R5 R6
  ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(clr & ~set)) |=> ((status & $past(clr & ~set)) == '0));
  // R11
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (set == '0 && clr == '0) |=> $stable(status));
endmodule

// File: rtl/irq_status_ctrl.sv
module irq_status_ctrl
  import irq_stat_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  input  logic              pwr_btn,
  input  logic              rtc_tick,
  input  logic              rtc_alarm,
  input  logic              rtc_upd_err,
  output logic              irq
);
  logic [WORD_W-1:0] mask, status, set;
  logic [NBYTE-1:0]  mask_wr, ack_wr;
  logic              btn_rise;

  irq_rise_detect u_btn (
    .clk(clk), .rst_n(rst_n), .lvl(pwr_btn), .rise(btn_rise)
  );

  always_comb begin
    set             = '0;
    set[TICK_BIT]   = rtc_tick;
    set[ALARM_BIT]  = rtc_alarm;
    set[UPDERR_BIT] = rtc_upd_err;
    set[BTN_BIT]    = btn_rise;
  end

  assign mask_wr = {wr_en && addr == A_MASK_HI, wr_en && addr == A_MASK_LO};
  assign ack_wr  = {wr_en && addr == A_ACK_HI,  wr_en && addr == A_ACK_LO};

  irq_byte_mask_reg #(.WORD_W(WORD_W), .DATA_W(DATA_W), .RST_VAL(MASK_RST)) u_mask (
    .clk(clk), .rst_n(rst_n), .wr_byte(mask_wr), .wr_data(wr_data), .mask(mask)
  );

  irq_sticky_status #(.WORD_W(WORD_W), .DATA_W(DATA_W)) u_stat (
    .clk(clk), .rst_n(rst_n), .set(set), .ack_byte(ack_wr),
    .ack_data(wr_data), .status(status)
  );

  always_comb begin
    unique case (addr)
      A_MASK_LO: rd_data = mask[DATA_W-1:0];
      A_MASK_HI: rd_data = mask[WORD_W-1:DATA_W];
      A_STAT_LO: rd_data = status[DATA_W-1:0];
      A_STAT_HI: rd_data = status[WORD_W-1:DATA_W];
      default:   rd_data = '0;
    endcase
  end

  assign irq = |(status & ~mask);

  // R2
  quiet_when_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (status == '0) |-> !irq);
  // R2
  quiet_when_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mask == '1) |-> !irq);
  // R8
  event_bits_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (status & ~EVT_BITS) == '0);
  // R7
  ack_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == A_ACK_LO || addr == A_ACK_HI) |-> rd_data == '0);
endmodule

// File: tb/test_irq_status_ctrl.sv
`timescale 1ns/1ps
module test_irq_status_ctrl;
  logic       clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0;
  logic [3:0] addr = '0;
  logic [7:0] wr_data = '0;
  logic       pwr_btn = 1'b0, rtc_tick = 1'b0, rtc_alarm = 1'b0, rtc_upd_err = 1'b0;
  logic [7:0] rd_data;
  logic       irq;

  int  checks = 0, errors = 0;
  bit  done = 0;
  logic chk_req = 1'b0;
  logic [7:0] exp_q[$];
  bit         kind_q[$];
  string      tag_q[$];

  irq_status_ctrl i_irq_status_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
    .rd_data(rd_data), .pwr_btn(pwr_btn), .rtc_tick(rtc_tick),
    .rtc_alarm(rtc_alarm), .rtc_upd_err(rtc_upd_err), .irq(irq)
  );

  always #4 clk = ~clk;

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    step(); wr_en = 1'b1; addr = a; wr_data = d;
    step(); wr_en = 1'b0;
  endtask

  task automatic push_chk(input bit k, input logic [3:0] a, input logic [7:0] e, input string t);
    step(); addr = a; exp_q.push_back(e); kind_q.push_back(k); tag_q.push_back(t); chk_req = 1'b1;
    step(); chk_req = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, input logic [7:0] e, input string t);
    push_chk(1'b0, a, e, t);
  endtask

  task automatic irq_is(input logic e, input string t);
    push_chk(1'b1, 4'h0, {7'b0, e}, t);
  endtask

  always @(negedge clk) begin : monitor
    logic [7:0] e, a;
    bit k;
    string t;
    if (chk_req) begin
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL monitor: empty queue actual %02h expected item", rd_data);
      end else begin
        e = exp_q.pop_front(); k = kind_q.pop_front(); t = tag_q.pop_front();
        a = k ? {7'b0, irq} : rd_data;
        checks++;
        if (a !== e) begin
          errors++;
          $display("FAIL %s actual %02h expected %02h", t, a, e);
        end
      end
    end
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run hung actual running expected done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) step();
    rst_n = 1'b1;
    // R1 reset state
    rd(4'h0, 8'hFF, "R1 mask low");
    rd(4'h1, 8'h0F, "R1 mask high");
    rd(4'h2, 8'h00, "R1 status low");
    rd(4'h3, 8'h00, "R1 status high");
    irq_is(1'b0, "R1 irq low");
    // R8 tick sets bit 8; masked so R2 irq stays low
    step(); rtc_tick = 1'b1; step(); rtc_tick = 1'b0;
    rd(4'h3, 8'h01, "R8 tick bit");
    irq_is(1'b0, "R2 masked tick");
    // R4 mask high write keeps low
    wr(4'h1, 8'h00);
    rd(4'h1, 8'h00, "R4 mask high load");
    rd(4'h0, 8'hFF, "R4 mask low kept");
    irq_is(1'b1, "R2 unmasked tick");
    // R5 ack low leaves high byte
    wr(4'h4, 8'hFF);
    rd(4'h3, 8'h01, "R5 ack low spares high");
    // R6 ack high clears
    wr(4'h5, 8'h01);
    rd(4'h3, 8'h00, "R6 ack high clears tick");
    irq_is(1'b0, "R2 irq drops after ack");
    // R8 alarm and update error
    step(); rtc_alarm = 1'b1; rtc_upd_err = 1'b1; step(); rtc_alarm = 1'b0; rtc_upd_err = 1'b0;
    rd(4'h3, 8'h06, "R8 alarm and upd err");
    wr(4'h5, 8'h02);
    rd(4'h3, 8'h04, "R6 selective ack");
    wr(4'h5, 8'h04);
    // R9 button edge only
    step(); pwr_btn = 1'b1;
    repeat (3) step();
    rd(4'h3, 8'h08, "R9 button rise");
    wr(4'h5, 8'h08);
    repeat (3) step();
    rd(4'h3, 8'h00, "R9 held level no re-set");
    pwr_btn = 1'b0; step(); pwr_btn = 1'b1; step();
    rd(4'h3, 8'h08, "R9 second rise");
    // R10 event beats ack on same bit
    step(); wr_en = 1'b1; addr = 4'h5; wr_data = 8'h01; rtc_tick = 1'b1;
    step(); wr_en = 1'b0; rtc_tick = 1'b0;
    rd(4'h3, 8'h09, "R10 event wins");
    wr(4'h5, 8'h09);
    rd(4'h3, 8'h00, "R6 clear both");
    // R3 mask low write keeps high
    wr(4'h0, 8'h5A);
    rd(4'h0, 8'h5A, "R3 mask low load");
    rd(4'h1, 8'h00, "R3 mask high kept");
    // R11 status is not writable
    wr(4'h3, 8'hFF);
    wr(4'h2, 8'hFF);
    rd(4'h3, 8'h00, "R11 status high unwritten");
    rd(4'h2, 8'h00, "R11 status low unwritten");
    // R7 zero reads
    rd(4'h4, 8'h00, "R7 ack low reads zero");
    rd(4'h5, 8'h00, "R7 ack high reads zero");
    rd(4'hF, 8'h00, "R7 unknown address");
    // R2 mask gating of button event
    wr(4'h1, 8'hF7);
    pwr_btn = 1'b0; step(); pwr_btn = 1'b1; step();
    rd(4'h3, 8'h08, "R9 rise with bit 11 unmasked");
    irq_is(1'b1, "R2 unmasked button");
    wr(4'h1, 8'hFF);
    irq_is(1'b0, "R2 masking drops irq");
    rd(4'h3, 8'h08, "R2 status kept under mask");
    step(); step();
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule